// File: doc/BRIEF.md
# Serial NOR Flash Read Responder

This block is the serial-side read path of a small NOR flash memory. The master drives SCK, CE# (`cs_n_i`) and SI. All three pins are brought into the system clock domain through synchronizers, and edges of SCK are found by comparing samples of it. While CE# is low, SI is captured on every rising SCK edge. The first eight bits form a command byte and the next 24 form a byte address, each sent MSB first. Two commands start a read. The plain read (0x03) starts data output straight after the address. The fast read (0x0B) first consumes one dummy byte, and the value of that byte does not matter.

Data leaves on SO, MSB first, with one bit per falling SCK edge. The byte pointer steps after every byte and rolls over from the top of the array to zero. The burst has no length limit and ends only when CE# rises. The array is a register file of `2**ADDR_W` bytes. A preload port, clocked by the system clock, fills it for test. The SO pad is driven only while `so_en_o` is high. Outside a data burst the line is high impedance.

Top module: `spi_flash_rd`

## Requirements
- R1: Command 0x03 followed by a 24-bit address (MSB first) starts a read. The first data bit is driven on the first falling SCK edge after the last address bit.
- R2: Command 0x0B takes the same address and then 8 dummy bits, whose values are ignored. Data starts on the first falling SCK edge after the last dummy bit.
- R3: Each byte is sent MSB first, and successive bytes come from successive addresses for as long as CE# stays low.
- R4: After the byte at address `2**ADDR_W-1`, the next byte comes from address 0.
- R5: Address bits at and above bit ADDR_W are ignored, so the start address is taken modulo the array depth.
- R6: Any other command value keeps `so_en_o` low for the rest of the transaction. The next transaction after CE# rises decodes normally.
- R7: `so_en_o` is low during the command, address and dummy phases, and whenever CE# is high.
- R8: CE# going high ends a transaction at any bit, including inside a data byte. The following transaction starts again at the command phase.
- R9: Both SCK idle levels work: low (mode 0) and high (mode 3). SO changes only after falling SCK edges.
- R10: A write on the preload port sets the array byte at `pre_addr_i`, and later reads return that value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; samples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master |
| cs_n_i | input | 1 | Active-low chip enable |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | SO pad drive enable; low means high impedance |
| pre_we_i | input | 1 | Preload write strobe |
| pre_addr_i | input | ADDR_W | Preload byte address |
| pre_data_i | input | 8 | Preload byte value |

## Verification
The assertions assume that the system clock oversamples SCK. Each SCK level and each CE# level is taken to last several system clocks, so no edge is lost in the synchronizers. The bench keeps every SCK half period at six system clocks. It also holds CE# high for at least twelve system clocks between transactions, and it drives SI well before each rising SCK edge. The preload port is used only while CE# is high, so array writes never race a burst.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned ADDR_BITS = 24;
  localparam int unsigned CNT_W     = 5;
  localparam logic [7:0]  OP_READ   = 8'h03;
  localparam logic [7:0]  OP_FAST   = 8'h0B;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_IGN
  } phase_e;
endpackage

// File: rtl/spi_rd_sync.sv
module spi_rd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  output logic cs_o,
  output logic si_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned NB = 3;
  localparam logic [NB-1:0] RST_VAL = 3'b010; // {si, cs_n, sck}

  logic [NB-1:0] pins;
  logic [NB-1:0] synced;
  logic          sck_d;

  assign pins = {si_i, cs_n_i, sck_i};

  for (genvar b = 0; b < NB; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[b]}};
      else         chain <= {chain[STAGES-2:0], pins[b]};
    end
    assign synced[b] = chain[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= synced[0];
  end

  assign cs_o   = synced[1];
  assign si_o   = synced[2];
  assign rise_o = synced[0] & ~sck_d;
  assign fall_o = ~synced[0] & sck_d;
endmodule

// File: rtl/spi_rd_mem.sv
module spi_rd_mem #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       fall_i,
  input  logic       run_i,
  input  logic [7:0] byte_i,
  output logic       take_o,
  output logic       bit_o,
  output logic       en_o
);
  logic [2:0] idx;
  logic [6:0] sr;

  assign take_o = run_i & fall_i & (idx == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx   <= '0;
      sr    <= '0;
      bit_o <= 1'b0;
      en_o  <= 1'b0;
    end else if (clr_i) begin
      idx  <= '0;
      en_o <= 1'b0;
    end else if (run_i && fall_i) begin
      en_o <= 1'b1;
      idx  <= idx + 3'd1;
      if (idx == 3'd0) begin
        bit_o <= byte_i[7];
        sr    <= byte_i[6:0];
      end else begin
        bit_o <= sr[6];
        sr    <= {sr[5:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_flash_rd.sv
module spi_flash_rd
  import spi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_en_o,
  input  logic              pre_we_i,
  input  logic [ADDR_W-1:0] pre_addr_i,
  input  logic [7:0]        pre_data_i
);
  localparam int unsigned SR_W = ADDR_W - 1;

  logic             cs_s, si_s, sck_rise, sck_fall;
  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic [SR_W-1:0]  in_sr;
  logic             fast;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]       rd_byte;
  logic             byte_take;
  logic             oe_q;
  logic [7:0]       op_now;
  logic [ADDR_W-1:0] addr_now;

  spi_rd_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .cs_n_i (cs_n_i),
    .si_i   (si_i),
    .cs_o   (cs_s),
    .si_o   (si_s),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_rd_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (pre_we_i),
    .waddr_i (pre_addr_i),
    .wdata_i (pre_data_i),
    .raddr_i (ptr),
    .rdata_o (rd_byte)
  );

  spi_rd_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_s),
    .fall_i (sck_fall),
    .run_i  (phase == PH_DATA),
    .byte_i (rd_byte),
    .take_o (byte_take),
    .bit_o  (so_o),
    .en_o   (oe_q)
  );

  assign op_now   = {in_sr[6:0], si_s};
  assign addr_now = {in_sr, si_s};
  // raw pin gate: pad releases at once when CE# rises
  assign so_en_o  = oe_q & ~cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase <= PH_CMD;
      cnt   <= '0;
      in_sr <= '0;
      fast  <= 1'b0;
      ptr   <= '0;
    end else if (cs_s) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else begin
      if (byte_take) ptr <= ptr + 1'b1;
      if (sck_rise) begin
        in_sr <= addr_now[SR_W-1:0];
        cnt   <= cnt + 1'b1;
        unique case (phase)
          PH_CMD: if (cnt == CNT_W'(7)) begin
            cnt   <= '0;
            fast  <= (op_now == OP_FAST);
            phase <= (op_now == OP_READ || op_now == OP_FAST) ? PH_ADDR : PH_IGN;
          end
          PH_ADDR: if (cnt == CNT_W'(ADDR_BITS - 1)) begin
            cnt   <= '0;
            ptr   <= addr_now;
            phase <= fast ? PH_DUMMY : PH_DATA;
          end
          PH_DUMMY: if (cnt == CNT_W'(7)) begin
            cnt   <= '0;
            phase <= PH_DATA;
          end
          default: cnt <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_flash_rd_chk.sv
module spi_flash_rd_chk
  import spi_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input phase_e            phase,
  input logic [CNT_W-1:0]  cnt,
  input logic [ADDR_W-1:0] ptr,
  input logic              cs_s,
  input logic              sck_fall,
  input logic              byte_take,
  input logic              so_o,
  input logic              so_en_o
);
  AST_OE_ONLY_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_en_o |-> phase == PH_DATA); // R7
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take |=> ptr == $past(ptr) + 1'b1); // R3
  AST_PTR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_take && ptr == '1) |=> ptr == '0); // R4
  AST_TAKE_IN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_take |-> phase == PH_DATA); // R3
  AST_IGN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_IGN |=> (phase == PH_IGN || phase == PH_CMD)); // R6
  AST_IGN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase == PH_IGN |-> !so_en_o); // R6
  AST_CS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> (phase == PH_CMD && cnt == '0)); // R8
  AST_SO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sck_fall |=> $stable(so_o)); // R9
endmodule

bind spi_flash_rd spi_flash_rd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase     (phase),
  .cnt       (cnt),
  .ptr       (ptr),
  .cs_s      (cs_s),
  .sck_fall  (sck_fall),
  .byte_take (byte_take),
  .so_o      (so_o),
  .so_en_o   (so_en_o)
);

// File: tb/sim_spi_flash_rd.sv
`timescale 1ns/1ps
module sim_spi_flash_rd;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned H      = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_en;
  logic pre_we = 1'b0;
  logic [ADDR_W-1:0] pre_addr = '0;
  logic [7:0] pre_data = '0;
  int n_chk = 0, n_fail = 0;
  logic mode3 = 1'b0;

  always #10 clk = ~clk;

  spi_flash_rd #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .cs_n_i(cs_n), .si_i(si),
    .so_o(so), .so_en_o(so_en), .pre_we_i(pre_we), .pre_addr_i(pre_addr),
    .pre_data_i(pre_data)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(int a, logic [7:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = ADDR_W'(a); pre_data = v;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic begin_tx(logic m3);
    mode3 = m3;
    sck = m3;
    waitc(2 * H);
    cs_n = 1'b0;
    waitc(H);
  endtask

  task automatic end_tx();
    waitc(H);
    if (!mode3) begin
      sck = 1'b0;
      waitc(H);
    end
    cs_n = 1'b1;
    waitc(2);
    check("R7 cs high releases SO", 32'(so_en), 0);
    waitc(2 * H);
  endtask

  task automatic send_byte(logic [7:0] v, string tag);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = v[i];
      waitc(H);
      sck = 1'b1;
      waitc(H);
    end
    check(tag, 32'(so_en), 0);
  endtask

  task automatic recv_byte(output logic [7:0] v, input string tag);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      waitc(H);
      v[i] = so;
      check(tag, 32'(so_en), 1);
      sck = 1'b1;
      waitc(H);
    end
  endtask

  task automatic read_burst(logic [7:0] op, logic [23:0] addr, int n, logic m3,
                            logic [7:0] dummy, string tag);
    logic [7:0] v;
    begin_tx(m3);
    send_byte(op, "R7 cmd phase");
    send_byte(addr[23:16], "R7 addr phase");
    send_byte(addr[15:8], "R7 addr phase");
    send_byte(addr[7:0], "R7 addr phase");
    if (op == 8'h0B) send_byte(dummy, "R7 dummy phase");
    for (int k = 0; k < n; k++) begin
      recv_byte(v, tag);
      check(tag, 32'(v), 32'(pat((int'(addr[ADDR_W-1:0]) + k) % DEPTH)));
    end
    end_tx();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    waitc(3);
    check("R7 reset so_en", 32'(so_en), 0);
    check("R7 reset so", 32'(so), 0);
    rst_ni = 1'b1;
    waitc(2);
    // R10: fill the array through the preload port
    for (int a = 0; a < DEPTH; a++) poke(a, pat(a));

    // R1 R3 R9: plain read, mode 0, start sweep
    for (int s = 0; s < DEPTH; s += 15)
      read_burst(8'h03, 24'(s), 2, 1'b0, 8'h00, "R1 R3 plain read mode0");
    // R2 R9: fast read, mode 3, start sweep
    for (int s = 3; s < DEPTH; s += 23)
      read_burst(8'h0B, 24'(s), 3, 1'b1, 8'hA5, "R2 R9 fast read mode3");
    // R2: dummy value must not matter
    read_burst(8'h0B, 24'h000040, 2, 1'b0, 8'h03, "R2 dummy ignored");
    read_burst(8'h0B, 24'h000040, 2, 1'b0, 8'hFF, "R2 dummy ignored");
    // R4: wrap from top to zero
    read_burst(8'h03, 24'h0000FD, 5, 1'b1, 8'h00, "R4 wrap plain");
    read_burst(8'h0B, 24'h0000FF, 3, 1'b0, 8'h5A, "R4 wrap fast");
    // R5: high address bits dropped
    read_burst(8'h03, 24'hABCD12, 2, 1'b0, 8'h00, "R5 high bits ignored");
    read_burst(8'h0B, 24'hFFFF00, 1, 1'b1, 8'h00, "R5 high bits ignored");

    // R6: unknown command stays silent
    begin_tx(1'b0);
    send_byte(8'h9F, "R6 bad cmd");
    for (int b = 0; b < 4; b++) begin
      for (int i = 0; i < 8; i++) begin
        sck = 1'b0; si = 1'b0;
        waitc(H);
        check("R6 silent after bad cmd", 32'(so_en), 0);
        sck = 1'b1;
        waitc(H);
      end
    end
    end_tx();
    read_burst(8'h03, 24'h000077, 1, 1'b0, 8'h00, "R6 recovers");

    // R8: CE# rises inside a data byte
    begin_tx(1'b1);
    send_byte(8'h03, "R7 cmd phase");
    send_byte(8'h00, "R7 addr phase");
    send_byte(8'h00, "R7 addr phase");
    send_byte(8'h40, "R7 addr phase");
    recv_byte(v, "R8 first byte");
    check("R8 first byte", 32'(v), 32'(pat(8'h40)));
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; waitc(H);
      check("R8 partial byte", 32'(so), 32'(pat(8'h41) >> (7 - i)) & 1);
      sck = 1'b1; waitc(H);
    end
    cs_n = 1'b1;
    waitc(1);
    check("R8 early stop releases SO", 32'(so_en), 0);
    waitc(2 * H);
    read_burst(8'h0B, 24'h000050, 2, 1'b0, 8'h00, "R8 restart after early stop");

    // R10: rewrite one byte, read it back, restore
    poke(8'h33, 8'hC3);
    begin_tx(1'b0);
    send_byte(8'h03, "R7 cmd phase");
    send_byte(8'h00, "R7 addr phase");
    send_byte(8'h00, "R7 addr phase");
    send_byte(8'h33, "R7 addr phase");
    recv_byte(v, "R10 preload");
    check("R10 preload", 32'(v), 32'hC3);
    end_tx();
    poke(8'h33, pat(8'h33));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule